// File: doc/BRIEF.md
# Three-Multiplier Rotation Butterfly

This block performs the plane rotation found in fast 8-point inverse DCT flow graphs. Given two signed samples `a` and `b` and a rotation pair (c1, c2), the rotation is `a' = c1*a + c2*b` and `b' = c1*b - c2*a`. The block needs only three multipliers. It forms one shared term `S = c2*(a + b)` and combines it with two further products against precomputed coefficients. The caller loads the coefficients `k_diff = c1 - c2` and `k_sum = c1 + c2` from its own coefficient store and presents them next to `c2`. The block never derives them.

Samples are 16-bit two's complement. Coefficients are 16-bit signed with 14 fractional bits. Each output is the exact full-precision sum, rounded half-up back to 16 bits and clamped to the signed 16-bit range. One sample pair can enter every cycle, and its result appears two cycles later with its own valid strobe. Between results, the outputs keep the last value they produced.

Top module: `rot_bfly`

## Requirements
- R1: When a sample is accepted, `y_first` later equals round(k_diff*x_first + c_shr*(x_first + x_second)), which for k_diff = c1 - c2 is round(c1*x_first + c2*x_second).
- R2: When a sample is accepted, `y_second` later equals round(k_sum*x_second - c_shr*(x_first + x_second)), which for k_sum = c1 + c2 is round(c1*x_second - c2*x_first).
- R3: Rounding adds 2^13 to the exact 2^-14-scaled sum and then shifts arithmetically right by 14, so an exact half LSB rounds toward positive infinity (+0.5 gives 1, -0.5 gives 0).
- R4: A rounded result above 32767 produces 32767, and one below -32768 produces -32768.
- R5: `out_valid` is high exactly two clock cycles after a cycle in which `in_valid` was high, and a new sample may be accepted on every cycle.
- R6: In a cycle where `out_valid` is low, `y_first` and `y_second` hold the values of the most recent result.
- R7: While `rst` is high at a clock edge, the pipeline clears, so `out_valid`, `y_first` and `y_second` read 0 afterwards.
- R8: The coefficients are sampled together with each sample, so they may differ from one accepted sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The sample and coefficients on the inputs are accepted this cycle |
| x_first | input | 16 | First input sample, signed |
| x_second | input | 16 | Second input sample, signed |
| c_shr | input | 16 | Shared coefficient c2, signed with 14 fractional bits |
| k_diff | input | 16 | Coefficient c1 - c2, signed with 14 fractional bits |
| k_sum | input | 16 | Coefficient c1 + c2, signed with 14 fractional bits |
| out_valid | output | 1 | The results on the outputs are new this cycle |
| y_first | output | 16 | First rotated result, signed |
| y_second | output | 16 | Second rotated result, signed |

## Verification
The bench builds the block with its package defaults: 16-bit samples, 16-bit coefficients and 14 fractional bits. With these widths, full-scale samples of -32768 paired with coefficients near +1.0 push the exact sum well past the output range, so both clamp limits can be reached. Exact half-LSB products can also be formed with both signs to exercise the round-half-up rule. Random coefficients are drawn within ±16383, so that c1 - c2 and c1 + c2 still fit in 16 bits. Each expected result comes from a direct four-product rotation, not from the shared-term form.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    localparam int DATA_W = 16;
    localparam int COEF_W = 16;
    localparam int FRAC_W = 14;

    localparam int SUM_W = DATA_W + 1;
    localparam int SHR_W = SUM_W + COEF_W;
    localparam int PRD_W = DATA_W + COEF_W;
    localparam int ACC_W = SHR_W + 2;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [SHR_W-1:0]  shared_t;
    typedef logic signed [PRD_W-1:0]  prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic    valid;
        shared_t shared;
        prod_t   p_first;
        prod_t   p_second;
    } stage1_t;

    typedef struct packed {
        logic    valid;
        sample_t y_first;
        sample_t y_second;
    } result_t;

    localparam acc_t RND_HALF = acc_t'(64'sd1 <<< (FRAC_W - 1));
    localparam acc_t OUT_MAX  = acc_t'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam acc_t OUT_MIN  = acc_t'(-(64'sd1 <<< (DATA_W - 1)));

    function automatic sample_t round_sat(input acc_t v);
        acc_t r;
        r = (v + RND_HALF) >>> FRAC_W;
        if (r > OUT_MAX) begin
            return sample_t'(OUT_MAX);
        end else if (r < OUT_MIN) begin
            return sample_t'(OUT_MIN);
        end
        return sample_t'(r);
    endfunction

endpackage

// File: rtl/rbf_prod.sv
module rbf_prod
    import rbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t x_first,
    input  sample_t x_second,
    input  coef_t   c_shr,
    input  coef_t   k_diff,
    input  coef_t   k_sum,
    output stage1_t s1
);

    sum_t    pair_sum;
    shared_t shared_nx;
    prod_t   p_first_nx;
    prod_t   p_second_nx;

    always_comb begin
        pair_sum    = sum_t'(x_first) + sum_t'(x_second);
        shared_nx   = shared_t'(pair_sum) * shared_t'(c_shr);
        p_first_nx  = prod_t'(x_first) * prod_t'(k_diff);
        p_second_nx = prod_t'(x_second) * prod_t'(k_sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.shared   <= shared_nx;
                s1.p_first  <= p_first_nx;
                s1.p_second <= p_second_nx;
            end
        end
    end

    assert_s1_lag_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (s1.valid == $past(in_valid)));

    assert_s1_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(s1.shared) && $stable(s1.p_first) && $stable(s1.p_second)));

    assert_zero_in_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && x_first == '0 && x_second == '0)
        |=> (s1.shared == '0 && s1.p_first == '0 && s1.p_second == '0));

endmodule

// File: rtl/rbf_join.sv
module rbf_join
    import rbf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stage1_t s1,
    output result_t res
);

    acc_t acc_first;
    acc_t acc_second;

    always_comb begin
        acc_first  = acc_t'(s1.p_first) + acc_t'(s1.shared);
        acc_second = acc_t'(s1.p_second) - acc_t'(s1.shared);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= s1.valid;
            if (s1.valid) begin
                res.y_first  <= round_sat(acc_first);
                res.y_second <= round_sat(acc_second);
            end
        end
    end

    assert_out_lag_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res.valid == $past(s1.valid)));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !s1.valid |=> ($stable(res.y_first) && $stable(res.y_second)));

    assert_clamp_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && acc_first > (OUT_MAX <<< FRAC_W))
        |=> (res.y_first == sample_t'(OUT_MAX)));

    assert_clamp_lo_R4: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && acc_second < (OUT_MIN <<< FRAC_W))
        |=> (res.y_second == sample_t'(OUT_MIN)));

endmodule

// File: rtl/rot_bfly.sv
module rot_bfly
    import rbf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] x_first,
    input  logic signed [DATA_W-1:0] x_second,
    input  logic signed [COEF_W-1:0] c_shr,
    input  logic signed [COEF_W-1:0] k_diff,
    input  logic signed [COEF_W-1:0] k_sum,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] y_first,
    output logic signed [DATA_W-1:0] y_second
);

    stage1_t s1;
    result_t res;

    rbf_prod u_prod (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x_first  (x_first),
        .x_second (x_second),
        .c_shr    (c_shr),
        .k_diff   (k_diff),
        .k_sum    (k_sum),
        .s1       (s1)
    );

    rbf_join u_join (
        .clk (clk),
        .rst (rst),
        .s1  (s1),
        .res (res)
    );

    assign out_valid = res.valid;
    assign y_first   = res.y_first;
    assign y_second  = res.y_second;

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && y_first == '0 && y_second == '0));

endmodule

// File: tb/rot_bfly_tb.sv
`timescale 1ns/1ps
module rot_bfly_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        in_valid;
    logic signed [15:0] x_first, x_second, c_shr, k_diff, k_sum;
    logic        out_valid;
    logic signed [15:0] y_first, y_second;

    rot_bfly u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_first(x_first), .x_second(x_second),
        .c_shr(c_shr), .k_diff(k_diff), .k_sum(k_sum),
        .out_valid(out_valid), .y_first(y_first), .y_second(y_second)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // expected pipeline: index 0 = driven last cycle, 1 = two cycles ago
    bit    pv [2];
    int    p1 [2];
    int    p2 [2];
    string ptag [2];
    int    held1 = 0;
    int    held2 = 0;

    function automatic int ref_round(longint v);
        longint r;
        r = (v + 64'sd8192) >>> 14;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge: check outputs, then drive next input
    task automatic step(bit vld, int a, int b, int c1, int c2, string tag);
        check({tag, " R5 valid"}, int'(out_valid), int'(pv[1]));
        check({pv[1] ? tag : "R6 hold", " first"},  int'(y_first),  p1[1]);
        check({pv[1] ? tag : "R6 hold", " second"}, int'(y_second), p2[1]);
        pv[1] = pv[0]; p1[1] = p1[0]; p2[1] = p2[0]; ptag[1] = ptag[0];
        in_valid = vld;
        x_first  = 16'(a);
        x_second = 16'(b);
        c_shr    = 16'(c2);
        k_diff   = 16'(c1 - c2);
        k_sum    = 16'(c1 + c2);
        if (vld) begin
            held1 = ref_round(longint'(c1) * a + longint'(c2) * b);
            held2 = ref_round(longint'(c1) * b - longint'(c2) * a);
        end
        pv[0] = vld; p1[0] = held1; p2[0] = held2; ptag[0] = tag;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20250611;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b1;
        x_first = 16'sd1000; x_second = 16'sd2000;
        c_shr = 16'sd100; k_diff = 16'sd200; k_sum = 16'sd300;
        repeat (4) @(negedge clk);
        check("R7 reset valid",  int'(out_valid), 0);
        check("R7 reset first",  int'(y_first),   0);
        check("R7 reset second", int'(y_second),  0);
        in_valid = 1'b0;
        for (int i = 0; i < 2; i++) begin pv[i] = 0; p1[i] = 0; p2[i] = 0; ptag[i] = "idle"; end
        rst = 1'b0;
        @(negedge clk);

        // directed corner cases
        step(1, 1, 0, 8192, 0, "R3 plus half");
        step(1, -1, 0, 8192, 0, "R3 minus half");
        step(1, 3, 0, 8192, 0, "R3 odd half");
        step(1, -32768, -32768, 16383, 16383, "R4 low clamp R1 R2");
        step(1, 32767, 32767, 16383, 16383, "R4 high clamp");
        step(1, -32768, 32767, 16383, -16383, "R4 mixed R2");
        step(1, 0, 0, 12345, -4321, "R1 R2 zero input");
        step(0, 77, 88, 1, 2, "R6 idle");
        step(0, 99, 11, 3, 4, "R6 idle");
        step(1, 32767, -32768, 16384 - 1, 0, "R1 R2 c2 zero");
        step(1, 1234, -5678, 0, 16383, "R1 R2 c1 zero");
        step(1, 1234, -5678, -16383, 9000, "R8 coef change");

        // random stream, valid roughly three cycles out of four
        for (int i = 0; i < 3000; i++) begin
            int a, b, c1, c2;
            bit v;
            v  = ($urandom % 4) != 0;
            a  = int'($urandom % 65536) - 32768;
            b  = int'($urandom % 65536) - 32768;
            c1 = int'($urandom % 32767) - 16383;
            c2 = int'($urandom % 32767) - 16383;
            step(v, a, b, c1, c2, "R1 R2 R8 random");
        end
        step(0, 0, 0, 0, 0, "flush");
        step(0, 0, 0, 0, 0, "flush");
        step(0, 0, 0, 0, 0, "flush");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule